// File: doc/BRIEF.md
# Counted Wait-State Generator for a Register Port Without Ready

This block sits between an ISA-style I/O bus and a peripheral whose registers have no ready output. When the address decode hits the register window and the device-select bit names this peripheral, a low IOR or IOW is passed on as a read or write strobe. The bus is then held off until the peripheral has had time to move its data. The peripheral signals that it has started by pulling its buffer-enable low. From that moment IOCHRDY is held low while a counter advances on a half-rate tick, which is the 20 MHz clock divided by two with a toggle flop. After `RDY_TICKS` ticks (default 4, about 400 ns) ready is released. The data-buffer enable opens only once the strobe is active and the peripheral has answered.

Some bus controllers sample ready before they drive the strobe. For these, a jumper input selects early mode. In early mode, not-ready is driven from the address decode alone, so ready is already low when the controller samples it. Because ready would then stay low forever if the peripheral never answered, early mode gives up after `TMO_TICKS` ticks without a buffer-enable and releases the bus with the data buffer kept closed. Normal mode is selected with the jumper input at 0.

The controller has six states. IDLE waits for a strobe. WAIT_BUF waits for the buffer-enable. COUNT holds the bus while the counter runs. DONE means ready has been released and the data buffer is open. TMO means the early-mode wait gave up. HOLD waits for the decode to drop. The transitions are:
- IDLE→WAIT_BUF when a strobe starts.
- WAIT_BUF→COUNT when the buffer-enable goes low.
- WAIT_BUF→TMO when the early-mode timeout expires.
- COUNT→DONE when the count completes.
- WAIT_BUF, COUNT, DONE or TMO→HOLD when the strobe ends.
- HOLD→IDLE when the decode drops.

Top module: `ws_wait_gen`

## Requirements
- R1: `prd_n` is low exactly while `win_hit`=1, `periph_pick`=1 and `ior_n`=0.
- R2: `pwr_n` is low exactly while `win_hit`=1, `periph_pick`=1 and `iow_n`=0; with `periph_pick`=0 neither strobe asserts and `iochrdy` stays 1.
- R3: In normal mode (`early_mode`=0), `iochrdy` stays 1 during a strobe until `bufen_n` goes low. It goes to 0 in the same cycle that `bufen_n` does.
- R4: After `bufen_n` falls, `iochrdy` stays 0 for `RDY_TICKS` ticks of the half-rate clock and then returns to 1. With the default value, this is 7 or 8 clock periods counted at mid-cycle, depending on the tick phase.
- R5: `dbuf_en_n` is 0 only while a strobe is active and after `bufen_n` has been seen low in that access. It returns to 1 as soon as the strobe ends.
- R6: In early mode (`early_mode`=1), `iochrdy` is 0 whenever `win_hit`=1 and `periph_pick`=1, before any strobe.
- R7: In early mode, if no `bufen_n` low arrives within `TMO_TICKS` ticks of the strobe, `iochrdy` is released and `dbuf_en_n` stays 1.
- R8: When the strobe ends, the count is abandoned and `iochrdy` returns to 1. A new strobe while the decode stays high starts no wait and opens no buffer until the decode has dropped.
- R9: During and right after reset, `iochrdy`=1, `dbuf_en_n`=1 and both strobes are 1 when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz clock |
| rst_n | input | 1 | Active-low reset |
| win_hit | input | 1 | Address decode of the register window |
| periph_pick | input | 1 | Device-select bit, 1 selects this peripheral |
| ior_n | input | 1 | Bus I/O read, active low |
| iow_n | input | 1 | Bus I/O write, active low |
| bufen_n | input | 1 | Peripheral buffer-enable, active low |
| early_mode | input | 1 | Jumper: 0 normal ready timing, 1 early not-ready |
| prd_n | output | 1 | Read strobe to the peripheral, active low |
| pwr_n | output | 1 | Write strobe to the peripheral, active low |
| dbuf_en_n | output | 1 | Data buffer enable, active low |
| iochrdy | output | 1 | Bus ready, 0 inserts wait states |

## Verification
The bench measures the length of each low pulse on `iochrdy` and compares it with the window allowed for both phases of the half-rate tick. A counter that stopped one tick early or one tick late would fall outside that window. It aborts an access in the middle of the count, then strobes again without dropping the decode. A design that failed to clear the count, or that restarted it, would show a second not-ready pulse or an open data buffer. In early mode it checks that ready falls on the decode alone. It also withholds the buffer-enable, so a design without the timeout would hang the bus, and a design that opened the buffer on timeout would be caught.

// File: rtl/ws_pkg.sv
package ws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_BUF = 3'd1,
        ST_COUNT    = 3'd2,
        ST_DONE     = 3'd3,
        ST_TMO      = 3'd4,
        ST_HOLD     = 3'd5
    } ws_state_e;
endpackage

// File: rtl/ws_halfrate.sv
// Toggle flop: a one-cycle tick on every second clock edge.
module ws_halfrate (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    assign tick = tog_q;
endmodule

// File: rtl/ws_tick_cnt.sv
// Up counter advanced by the half-rate tick, cleared synchronously.
module ws_tick_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (en)       q <= q + 1'b1;
    end
endmodule

// File: rtl/ws_strobe_dec.sv
// Qualifies the bus strobes with the window decode and the device select.
module ws_strobe_dec (
    input  logic win_hit,
    input  logic periph_pick,
    input  logic ior_n,
    input  logic iow_n,
    output logic sel,
    output logic rd_act,
    output logic wr_act
);
    assign sel    = win_hit & periph_pick;
    assign rd_act = sel & ~ior_n;
    assign wr_act = sel & ~iow_n;
endmodule

// File: rtl/ws_wait_gen.sv
module ws_wait_gen #(
    parameter int RDY_TICKS = 4,
    parameter int TMO_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_hit,
    input  logic periph_pick,
    input  logic ior_n,
    input  logic iow_n,
    input  logic bufen_n,
    input  logic early_mode,
    output logic prd_n,
    output logic pwr_n,
    output logic dbuf_en_n,
    output logic iochrdy
);
    import ws_pkg::*;

    localparam int MAXT = (TMO_TICKS > RDY_TICKS) ? TMO_TICKS : RDY_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    ws_state_e state_q, state_d;
    logic sel, rd_act, wr_act, strobe;
    logic tick, cnt_clr, rdy_hit, tmo_hit;
    logic [CW-1:0] cnt;

    ws_strobe_dec u_dec (
        .win_hit    (win_hit),
        .periph_pick(periph_pick),
        .ior_n      (ior_n),
        .iow_n      (iow_n),
        .sel        (sel),
        .rd_act     (rd_act),
        .wr_act     (wr_act)
    );

    ws_halfrate u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    ws_tick_cnt #(.W(CW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .en   (tick),
        .q    (cnt)
    );

    assign strobe  = rd_act | wr_act;
    assign cnt_clr = (state_q != state_d);
    assign rdy_hit = tick && (cnt == CW'(RDY_TICKS - 1));
    assign tmo_hit = tick && (cnt == CW'(TMO_TICKS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe) state_d = ST_WAIT_BUF;
            end
            ST_WAIT_BUF: begin
                if (!strobe)                  state_d = ST_HOLD;
                else if (!bufen_n)            state_d = ST_COUNT;
                else if (early_mode && tmo_hit) state_d = ST_TMO;
            end
            ST_COUNT: begin
                if (!strobe)      state_d = ST_HOLD;
                else if (rdy_hit) state_d = ST_DONE;
            end
            ST_DONE, ST_TMO: begin
                if (!strobe) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!sel) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        prd_n     = ~rd_act;
        pwr_n     = ~wr_act;
        dbuf_en_n = 1'b1;
        iochrdy   = 1'b1;
        unique case (state_q)
            ST_IDLE:     iochrdy = ~(early_mode & sel);
            ST_WAIT_BUF: iochrdy = ~(early_mode | ~bufen_n);
            ST_COUNT: begin
                iochrdy   = 1'b0;
                dbuf_en_n = ~strobe;
            end
            ST_DONE:     dbuf_en_n = ~strobe;
            ST_TMO, ST_HOLD: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/ws_wait_gen_chk.sv
module ws_wait_gen_chk #(
    parameter int RDY_TICKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic win_hit,
    input logic periph_pick,
    input logic bufen_n,
    input logic early_mode,
    input logic prd_n,
    input logic pwr_n,
    input logic dbuf_en_n,
    input logic iochrdy,
    input ws_pkg::ws_state_e state_q
);
    import ws_pkg::*;

    logic [7:0] lowrun;

    always_ff @(posedge clk) begin
        if (!rst_n || early_mode) lowrun <= '0;
        else if (!iochrdy)        lowrun <= (lowrun == 8'hFF) ? lowrun : lowrun + 1'b1;
        else                      lowrun <= '0;
    end

    AST_BUF_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !dbuf_en_n |-> (!prd_n || !pwr_n)); // R5
    AST_NRDY_FROM_BUFEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!early_mode && $fell(iochrdy)) |-> !bufen_n); // R3
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !early_mode |-> (lowrun <= 8'(2 * RDY_TICKS + 1))); // R4
    AST_EARLY_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (early_mode && win_hit && periph_pick && state_q == ST_IDLE) |-> !iochrdy); // R6
    AST_TMO_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TMO) |-> dbuf_en_n); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q != ST_WAIT_BUF)); // R8
endmodule

bind ws_wait_gen ws_wait_gen_chk #(.RDY_TICKS(RDY_TICKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_hit    (win_hit),
    .periph_pick(periph_pick),
    .bufen_n    (bufen_n),
    .early_mode (early_mode),
    .prd_n      (prd_n),
    .pwr_n      (pwr_n),
    .dbuf_en_n  (dbuf_en_n),
    .iochrdy    (iochrdy),
    .state_q    (state_q)
);

// File: tb/tb_ws_wait_gen.sv
module tb_ws_wait_gen;
    localparam int CLK_PERIOD = 50;
    localparam int RDY = 4;
    localparam int TMO = 16;

    typedef struct {
        string req;
        int    lo;
        int    hi;
    } run_exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_hit = 1'b0, periph_pick = 1'b0, ior_n = 1'b1, iow_n = 1'b1;
    logic bufen_n = 1'b1, early_mode = 1'b0;
    logic prd_n, pwr_n, dbuf_en_n, iochrdy;

    int n_chk = 0;
    int n_bad = 0;
    run_exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ws_wait_gen #(.RDY_TICKS(RDY), .TMO_TICKS(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .win_hit(win_hit), .periph_pick(periph_pick),
        .ior_n(ior_n), .iow_n(iow_n), .bufen_n(bufen_n), .early_mode(early_mode),
        .prd_n(prd_n), .pwr_n(pwr_n), .dbuf_en_n(dbuf_en_n), .iochrdy(iochrdy)
    );

    task automatic chk(input string req, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic expect_run(input string req, input int lo, input int hi);
        run_exp_t e;
        e.req = req; e.lo = lo; e.hi = hi;
        exp_q.push_back(e);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: measures each not-ready pulse, in samples taken a quarter period after the rising edge
    initial begin
        int run;
        run = 0;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (rst_n && iochrdy === 1'b0) run++;
            else if (run > 0) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected not-ready pulse: got %0d expected none", run);
                end else begin
                    run_exp_t e;
                    e = exp_q.pop_front();
                    if (run < e.lo || run > e.hi) begin
                        n_bad++;
                        $display("FAIL %s: not-ready length got %0d expected %0d..%0d",
                                 e.req, run, e.lo, e.hi);
                    end
                end
                run = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        // R9 reset state
        chk("R9 iochrdy in reset", iochrdy, 1'b1);
        chk("R9 dbuf in reset", dbuf_en_n, 1'b1);
        rst_n = 1'b1;
        cyc(2);
        chk("R9 prd idle", prd_n, 1'b1);
        chk("R9 pwr idle", pwr_n, 1'b1);
        chk("R9 iochrdy idle", iochrdy, 1'b1);

        // R1/R3/R4/R5 normal read
        win_hit = 1; periph_pick = 1; ior_n = 0;
        #1;
        chk("R1 read strobe", prd_n, 1'b0);
        chk("R1 no write strobe", pwr_n, 1'b1);
        cyc(3);
        chk("R3 ready held before bufen", iochrdy, 1'b1);
        chk("R5 buffer closed before bufen", dbuf_en_n, 1'b1);
        expect_run("R4 normal read", 2 * RDY - 1, 2 * RDY);
        bufen_n = 0;
        #1;
        chk("R3 not-ready on bufen", iochrdy, 1'b0);
        cyc(1);
        chk("R5 buffer open after bufen", dbuf_en_n, 1'b0);
        cyc(12);
        chk("R4 ready released", iochrdy, 1'b1);
        chk("R5 buffer open while strobe", dbuf_en_n, 1'b0);
        bufen_n = 1; ior_n = 1;
        #1;
        chk("R5 buffer closes with strobe", dbuf_en_n, 1'b1);
        chk("R1 strobe ends", prd_n, 1'b1);
        cyc(1);
        win_hit = 0;
        cyc(2);

        // R2 device not selected, then a write
        win_hit = 1; periph_pick = 0; iow_n = 0;
        cyc(3);
        chk("R2 no strobe when unselected", pwr_n, 1'b1);
        chk("R2 no wait when unselected", iochrdy, 1'b1);
        iow_n = 1; win_hit = 0;
        cyc(2);
        win_hit = 1; periph_pick = 1; iow_n = 0;
        #1;
        chk("R2 write strobe", pwr_n, 1'b0);
        chk("R2 no read strobe", prd_n, 1'b1);
        cyc(2);
        expect_run("R4 normal write", 2 * RDY - 1, 2 * RDY);
        bufen_n = 0;
        cyc(14);
        chk("R4 write ready released", iochrdy, 1'b1);
        bufen_n = 1; iow_n = 1;

        // R8 second strobe without decode drop
        cyc(2);
        ior_n = 0; bufen_n = 0;
        cyc(6);
        chk("R8 no restart ready", iochrdy, 1'b1);
        chk("R8 no restart buffer", dbuf_en_n, 1'b1);
        ior_n = 1; bufen_n = 1; win_hit = 0;
        cyc(2);

        // R8 abort in the middle of the count
        win_hit = 1; ior_n = 0;
        cyc(2);
        expect_run("R8 abort", 3, 3);
        bufen_n = 0;
        cyc(3);
        ior_n = 1;
        #1;
        chk("R8 buffer closes on abort", dbuf_en_n, 1'b1);
        cyc(2);
        chk("R8 ready after abort", iochrdy, 1'b1);
        bufen_n = 1; win_hit = 0;
        cyc(3);

        // R6 early mode with an answer
        early_mode = 1;
        cyc(1);
        expect_run("R6 early read", 2 * RDY + 2, 2 * RDY + 3);
        win_hit = 1; periph_pick = 1;
        #1;
        chk("R6 not-ready on decode", iochrdy, 1'b0);
        cyc(2);
        ior_n = 0; bufen_n = 0;
        cyc(16);
        chk("R6 ready released", iochrdy, 1'b1);
        chk("R5 early buffer open", dbuf_en_n, 1'b0);
        ior_n = 1; bufen_n = 1;
        cyc(1);
        win_hit = 0;
        cyc(2);

        // R7 early mode timeout
        expect_run("R7 timeout", 2 * TMO + 1, 2 * TMO + 2);
        win_hit = 1;
        cyc(2);
        ior_n = 0;
        cyc(40);
        chk("R7 ready after timeout", iochrdy, 1'b1);
        chk("R7 buffer closed after timeout", dbuf_en_n, 1'b1);
        ior_n = 1;
        cyc(1);
        win_hit = 0;
        early_mode = 0;
        cyc(4);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R4 pulses missing: got %0d outstanding expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule